// File: doc/BRIEF.md
# Power Management Control and Status Register

This block is a 16-bit control and status register that governs the power state of one peripheral function. Software reaches it through a small configuration write/read port with a register address and two byte enables. The register holds a two-bit device power state, an enable for wake requests, and a sticky wake-event flag. Hardware sets the flag and software clears it by writing one.

The power state drives the function's surroundings directly. Leaving full power forces the function's interrupt output inactive. Entering the full-off state also disables memory-space decode, but the configuration port stays usable. Writes that ask for one of the two intermediate state codes complete normally but change nothing. When software moves the function from full-off back to full-on, the block issues a one-cycle soft reset pulse to the function.

The wake flag and its enable are kept on a separate always-on reset. They survive both the main core reset and the soft reset, so a wake cause recorded while the function was powered down is still readable after the function returns.

Top module: `pm_ctrl_reg`

## Requirements
- R1: After both resets the register reads 0000h at address REG_ADDR. A read at any other address returns 0, and a write to any other address changes nothing.
- R2: Bit 15 (wake status) is set by wake_evt_i whatever the enable holds. Writing 1 to bit 15 with byte enable 1 set clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clearing write leaves the bit set.
- R3: Bit 8 (wake enable) is read/write. wake_req_o is high exactly when bit 15 and bit 8 are both 1.
- R4: Bits 14:9 and 7:2 always read 0, and writes to them have no effect.
- R5: Bits 1:0 hold the power state, with 00 meaning full-on and 11 meaning full-off. A write of 01 or 10 completes but leaves the state unchanged.
- R6: mem_dec_en_o is low while the state is 11 and high while it is 00. The register stays writable and readable in state 11.
- R7: irq_o follows fn_irq_i in state 00 and is 0 in any other state.
- R8: A write of 00 while the state is 11 makes soft_rst_o high for exactly the one cycle after the write. Any other write gives no pulse, and the pulse does not change bits 15 and 8.
- R9: rst_ni returns bits 1:0 to 00 and leaves bits 15 and 8 unchanged. Only aon_rst_ni clears bits 15 and 8.
- R10: A write reaches bits 7:0 only when cfg_be_i[0] is 1, and reaches bits 15:8 only when cfg_be_i[1] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Core reset, asynchronous, active low |
| aon_rst_ni | input | 1 | Always-on reset, asynchronous, active low |
| cfg_addr_i | input | ADDR_W | Configuration register address |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_be_i | input | 2 | Byte enables for the write |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Read data, combinational from the address |
| wake_evt_i | input | 1 | Wake event from the function |
| fn_irq_i | input | 1 | Interrupt from the function |
| irq_o | output | 1 | Interrupt after power-state gating |
| mem_dec_en_o | output | 1 | Memory-space decode enable |
| wake_req_o | output | 1 | Internal wake request |
| soft_rst_o | output | 1 | One-cycle soft reset of the function |

## Verification
The bench builds the block with its default ADDR_W of 8 and REG_ADDR of 60h. That register space is small enough to probe a wrong address directly. The sweep covers both reachable power states, all four byte-enable patterns, all sixteen combinations of the written status, enable and state bits, and the wake event both present and absent. Every pulse, drop and set-over-clear case is therefore reached. Separate phases toggle each reset alone to show which fields each reset owns.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
  localparam int REG_W   = 16;
  localparam int STS_BIT = 15;
  localparam int EN_BIT  = 8;
  localparam int BE_W    = REG_W / 8;

  typedef logic [1:0] pstate_t;
  localparam pstate_t PS_ON  = 2'b00;
  localparam pstate_t PS_OFF = 2'b11;
endpackage

// File: rtl/pm_wake_ctl.sv
`timescale 1ns/1ps
// Wake status/enable, always-on domain only
module pm_wake_ctl (
  input  logic clk_i,
  input  logic aon_rst_ni,
  input  logic evt_i,
  input  logic hi_wr_i,
  input  logic clr_i,
  input  logic en_d_i,
  output logic sts_o,
  output logic en_o
);
  logic sts_q, en_q;

  always_ff @(posedge clk_i or negedge aon_rst_ni) begin
    if (!aon_rst_ni) begin
      sts_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      // set wins over clear
      if (evt_i)                sts_q <= 1'b1;
      else if (hi_wr_i && clr_i) sts_q <= 1'b0;
      if (hi_wr_i) en_q <= en_d_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
endmodule

// File: rtl/pm_state_ctl.sv
`timescale 1ns/1ps
module pm_state_ctl
  import pm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    lo_wr_i,
  input  pstate_t ps_d_i,
  output pstate_t ps_o,
  output logic    soft_rst_o
);
  pstate_t ps_q;
  logic    soft_q;
  logic    legal, wake_up;

  assign legal   = (ps_d_i == PS_ON) || (ps_d_i == PS_OFF);
  assign wake_up = lo_wr_i && (ps_q == PS_OFF) && (ps_d_i == PS_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q   <= PS_ON;
      soft_q <= 1'b0;
    end else begin
      soft_q <= wake_up;
      if (lo_wr_i && legal) ps_q <= ps_d_i;
    end
  end

  assign ps_o       = ps_q;
  assign soft_rst_o = soft_q;
endmodule

// File: rtl/pm_gate.sv
`timescale 1ns/1ps
module pm_gate
  import pm_pkg::*;
(
  input  pstate_t ps_i,
  input  logic    fn_irq_i,
  input  logic    sts_i,
  input  logic    en_i,
  output logic    irq_o,
  output logic    mem_dec_en_o,
  output logic    wake_req_o
);
  assign irq_o        = fn_irq_i && (ps_i == PS_ON);
  assign mem_dec_en_o = (ps_i != PS_OFF);
  assign wake_req_o   = sts_i && en_i;
endmodule

// File: rtl/pm_ctrl_reg.sv
`timescale 1ns/1ps
module pm_ctrl_reg
  import pm_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              aon_rst_ni,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_wr_i,
  input  logic [BE_W-1:0]   cfg_be_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic              wake_evt_i,
  input  logic              fn_irq_i,
  output logic              irq_o,
  output logic              mem_dec_en_o,
  output logic              wake_req_o,
  output logic              soft_rst_o
);
  logic    sel, wr_hit, lo_wr, hi_wr;
  logic    sts, en;
  pstate_t ps;
  logic    unused_wdata;

  assign sel    = (cfg_addr_i == REG_ADDR);
  assign wr_hit = cfg_wr_i && sel;
  assign lo_wr  = wr_hit && cfg_be_i[0];
  assign hi_wr  = wr_hit && cfg_be_i[1];
  assign unused_wdata = ^{cfg_wdata_i[14:9], cfg_wdata_i[7:2]};

  pm_wake_ctl u_wake (
    .clk_i      (clk_i),
    .aon_rst_ni (aon_rst_ni),
    .evt_i      (wake_evt_i),
    .hi_wr_i    (hi_wr),
    .clr_i      (cfg_wdata_i[STS_BIT]),
    .en_d_i     (cfg_wdata_i[EN_BIT]),
    .sts_o      (sts),
    .en_o       (en)
  );

  pm_state_ctl u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lo_wr_i    (lo_wr),
    .ps_d_i     (cfg_wdata_i[1:0]),
    .ps_o       (ps),
    .soft_rst_o (soft_rst_o)
  );

  pm_gate u_gate (
    .ps_i         (ps),
    .fn_irq_i     (fn_irq_i),
    .sts_i        (sts),
    .en_i         (en),
    .irq_o        (irq_o),
    .mem_dec_en_o (mem_dec_en_o),
    .wake_req_o   (wake_req_o)
  );

  always_comb begin
    cfg_rdata_o = '0;
    if (sel) begin
      cfg_rdata_o[STS_BIT] = sts;
      cfg_rdata_o[EN_BIT]  = en;
      cfg_rdata_o[1:0]     = ps;
    end
  end
endmodule

// File: rtl/pm_ctrl_reg_chk.sv
`timescale 1ns/1ps
module pm_ctrl_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        aon_rst_ni,
  input logic        wr_hit,
  input logic [1:0]  cfg_be_i,
  input logic [15:0] cfg_wdata_i,
  input logic [1:0]  ps,
  input logic        sts,
  input logic        en,
  input logic        wake_evt_i,
  input logic        irq_o,
  input logic        mem_dec_en_o,
  input logic        wake_req_o,
  input logic        soft_rst_o
);
  p_sts_set_r2: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
    wake_evt_i |=> sts);
  p_sts_hold_r2: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
    (sts && !(wr_hit && cfg_be_i[1] && cfg_wdata_i[15])) |=> sts);
  p_wake_req_r3: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
    wake_req_o == (sts && en));
  p_drop_illegal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && cfg_be_i[0] && (cfg_wdata_i[1] ^ cfg_wdata_i[0])) |=> $stable(ps));
  p_mem_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps == 2'b11) |-> !mem_dec_en_o);
  p_irq_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps != 2'b00) |-> !irq_o);
  p_soft_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);
  p_soft_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (ps == 2'b00 && $past(ps) == 2'b11));
endmodule

bind pm_ctrl_reg pm_ctrl_reg_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .aon_rst_ni   (aon_rst_ni),
  .wr_hit       (wr_hit),
  .cfg_be_i     (cfg_be_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .ps           (ps),
  .sts          (sts),
  .en           (en),
  .wake_evt_i   (wake_evt_i),
  .irq_o        (irq_o),
  .mem_dec_en_o (mem_dec_en_o),
  .wake_req_o   (wake_req_o),
  .soft_rst_o   (soft_rst_o)
);

// File: tb/pm_ctrl_reg_test.sv
`timescale 1ns/1ps
module pm_ctrl_reg_test;
  localparam logic [7:0] RA = 8'h60;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, aon_rst_ni = 1'b0;
  logic [7:0]  cfg_addr_i = RA;
  logic        cfg_wr_i = 1'b0;
  logic [1:0]  cfg_be_i = 2'b00;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        wake_evt_i = 1'b0, fn_irq_i = 1'b1;
  logic        irq_o, mem_dec_en_o, wake_req_o, soft_rst_o;

  int n_chk = 0, n_bad = 0;
  logic m_sts = 1'b0, m_en = 1'b0;
  logic [1:0] m_ps = 2'b00;

  always #10 clk = ~clk;

  pm_ctrl_reg uut (
    .clk_i(clk), .rst_ni(rst_ni), .aon_rst_ni(aon_rst_ni),
    .cfg_addr_i(cfg_addr_i), .cfg_wr_i(cfg_wr_i), .cfg_be_i(cfg_be_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .wake_evt_i(wake_evt_i), .fn_irq_i(fn_irq_i), .irq_o(irq_o),
    .mem_dec_en_o(mem_dec_en_o), .wake_req_o(wake_req_o), .soft_rst_o(soft_rst_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input logic pulse);
    chk("R2 status bit", {15'd0, cfg_rdata_o[15]}, {15'd0, m_sts});
    chk("R3 enable bit", {15'd0, cfg_rdata_o[8]}, {15'd0, m_en});
    chk("R3 wake_req_o", {15'd0, wake_req_o}, {15'd0, m_sts & m_en});
    chk("R4 reserved zero", cfg_rdata_o & 16'h7EFC, 16'h0000);
    chk("R5 power state", {14'd0, cfg_rdata_o[1:0]}, {14'd0, m_ps});
    chk("R6 mem_dec_en_o", {15'd0, mem_dec_en_o}, {15'd0, m_ps != 2'b11});
    chk("R7 irq_o", {15'd0, irq_o}, {15'd0, fn_irq_i & (m_ps == 2'b00)});
    chk("R8 soft_rst_o", {15'd0, soft_rst_o}, {15'd0, pulse});
  endtask

  // one write cycle, optional simultaneous wake event; model per R2/R3/R5/R8/R10
  task automatic wr(input logic [1:0] be, input logic [15:0] d, input logic evt);
    logic pulse;
    @(negedge clk);
    cfg_addr_i = RA; cfg_wr_i = 1'b1; cfg_be_i = be; cfg_wdata_i = d; wake_evt_i = evt;
    pulse = 1'b0;
    if (evt) m_sts = 1'b1;
    else if (be[1] && d[15]) m_sts = 1'b0;
    if (be[1]) m_en = d[8];
    if (be[0]) begin
      if (d[1:0] == 2'b00) begin
        pulse = (m_ps == 2'b11);
        m_ps = 2'b00;
      end else if (d[1:0] == 2'b11) m_ps = 2'b11;
    end
    @(negedge clk);
    cfg_wr_i = 1'b0; cfg_be_i = 2'b00; wake_evt_i = 1'b0;
    #1 chk_all(pulse);
    @(negedge clk);
    #1 chk("R8 pulse ends", {15'd0, soft_rst_o}, 16'h0000);
  endtask

  task automatic evt_only();
    @(negedge clk); wake_evt_i = 1'b1; m_sts = 1'b1;
    @(negedge clk); wake_evt_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; aon_rst_ni = 1'b1;
    @(negedge clk);
    #1 chk("R1 reset value", cfg_rdata_o, 16'h0000);
    chk_all(1'b0);

    // R1: wrong address write and read
    @(negedge clk);
    cfg_addr_i = RA + 8'd1; cfg_wr_i = 1'b1; cfg_be_i = 2'b11; cfg_wdata_i = 16'hFFFF;
    #1 chk("R1 other address reads 0", cfg_rdata_o, 16'h0000);
    @(negedge clk);
    cfg_wr_i = 1'b0; cfg_addr_i = RA;
    #1 chk("R1 other address write ignored", cfg_rdata_o, 16'h0000);

    // main sweep (R2 R3 R4 R5 R6 R7 R8 R10)
    for (int s = 0; s < 2; s++)
      for (int be = 0; be < 4; be++)
        for (int v = 0; v < 16; v++)
          for (int e = 0; e < 2; e++) begin
            logic [15:0] d;
            wr(2'b01, s ? 16'h0003 : 16'h0000, 1'b0);
            if (((v + be) % 2) == 1) evt_only();
            fn_irq_i = ((v + e) % 3) != 0;
            d = 16'h7EFC;
            d[15] = v[3]; d[8] = v[2]; d[1:0] = v[1:0];
            wr(be[1:0], d, e[0]);
          end
    fn_irq_i = 1'b1;

    // R9: core reset keeps wake bits, clears state
    wr(2'b11, 16'h0103, 1'b1);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1; m_ps = 2'b00;
    #1 chk("R9 core reset keeps wake bits", cfg_rdata_o, 16'h8100);
    chk_all(1'b0);

    // R9: always-on reset clears wake bits only
    wr(2'b01, 16'h0003, 1'b0);
    @(negedge clk); aon_rst_ni = 1'b0;
    @(negedge clk); aon_rst_ni = 1'b1; m_sts = 1'b0; m_en = 1'b0;
    #1 chk("R9 always-on reset clears wake bits", cfg_rdata_o, 16'h0003);
    chk_all(1'b0);

    // R8: wake-up pulse leaves wake bits alone
    wr(2'b10, 16'h0100, 1'b1);
    wr(2'b01, 16'h0000, 1'b0);
    chk("R8 wake bits after soft reset", cfg_rdata_o, 16'h8100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule